// File: doc/BRIEF.md
# Instruction Group Dependency Checker

This block watches a stream of decoded instruction bundles, three slots per 128-bit bundle, and enforces the rule that an instruction group may not carry a register hazard. A group is the run of slots between stop marks; a stop may sit on any slot, so a group can end inside a bundle, and a group can also stretch over many bundles. Inside a group, a slot that reads a register an earlier slot of that group wrote is a read-after-write hazard, and a slot that writes a register an earlier slot already wrote is a write-after-write hazard. Both are reported. Ordering through memory is legal inside a group, so the memory-operation flag never produces a report.

A 128-entry written-register scoreboard holds the destinations recorded since the last stop. The three slots of a presented bundle are evaluated in slot order within a single cycle, so each slot sees the writes of the slots before it. The cycle after a bundle, the block reports a per-slot hazard map, a violation pulse, and the index of the lowest offending slot. A hazard is only reported; it does not stop the offending slot's destination from being recorded.

Top module: `isg_dep_checker`

## Requirements
- R1: A slot whose valid source register (either source) is already recorded in the current group is flagged, including a register written by a lower-numbered slot of the same bundle.
- R2: A slot whose valid destination register is already recorded in the current group is flagged.
- R3: A slot with its stop flag set ends the group after itself: slots after it in the same bundle, and every later bundle, start from an empty scoreboard.
- R4: Without a stop, a group carries over to later bundles, so a hazard against a register written in an earlier bundle is flagged.
- R5: Register 0 is never recorded, and a read or write of register 0 never causes a flag.
- R6: The memory-operation flag has no effect on any output; a read of a register followed by a write of it, or two reads of the same register, are not flagged.
- R7: One cycle after a valid bundle, viol_map_o bit i is set exactly when slot i (slot 0 first in order) is flagged, viol_o is set when any bit is set, and viol_slot_o is the lowest flagged slot index (0 when none); after a cycle without a bundle all three are zero.
- R8: A flagged slot still records its destination register.
- R9: A cycle with bndl_vld_i low leaves the scoreboard unchanged.
- R10: After reset the scoreboard is empty and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bndl_vld_i | input | 1 | A bundle is presented this cycle |
| slot_src_a_i | input | 3x7 | First source register per slot |
| slot_src_a_vld_i | input | 3 | First source is used, per slot |
| slot_src_b_i | input | 3x7 | Second source register per slot |
| slot_src_b_vld_i | input | 3 | Second source is used, per slot |
| slot_dst_i | input | 3x7 | Destination register per slot |
| slot_dst_vld_i | input | 3 | Destination is written, per slot |
| slot_mem_i | input | 3 | Slot is a memory operation |
| slot_stop_i | input | 3 | Group ends after this slot |
| viol_o | output | 1 | Hazard found in the previous bundle |
| viol_slot_o | output | 2 | Lowest flagged slot index |
| viol_map_o | output | 3 | Per-slot hazard flags, bit i = slot i |

## Verification
A scoreboard bit left set when it should have cleared shows up as a false hazard on the very next bundle that touches that register, and a bit that failed to set shows up as a missing hazard; either appears at the ports one cycle after the bundle that reveals it. Because random register numbers are drawn from a small pool with frequent stops, stale or missing scoreboard state is exposed within a few bundles rather than lingering. Mid-bundle stops, register 0, idle gaps and multi-slot hazards are forced by directed bundles so the in-bundle forwarding order is checked explicitly.

// File: rtl/isg_pkg.sv
package isg_pkg;
  localparam int ISG_NREG_DEF  = 128;
  localparam int ISG_SLOTS_DEF = 3;

  // a register operand takes part in hazard tracking only when used and nonzero
  function automatic logic live_reg(input logic used, input logic [15:0] num);
    return used && (num != 16'd0);
  endfunction
endpackage

// File: rtl/isg_slot_stage.sv
module isg_slot_stage
  import isg_pkg::*;
#(
  parameter int NREG = ISG_NREG_DEF,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NREG-1:0] sb_i,
  input  logic [RW-1:0]   src_a_i,
  input  logic            src_a_vld_i,
  input  logic [RW-1:0]   src_b_i,
  input  logic            src_b_vld_i,
  input  logic [RW-1:0]   dst_i,
  input  logic            dst_vld_i,
  input  logic            stop_i,
  output logic            hit_o,
  output logic [NREG-1:0] sb_o
);
  logic a_live, b_live, d_live;
  logic raw_hit, waw_hit;

  assign a_live = live_reg(src_a_vld_i, 16'(src_a_i));
  assign b_live = live_reg(src_b_vld_i, 16'(src_b_i));
  assign d_live = live_reg(dst_vld_i,   16'(dst_i));

  assign raw_hit = (a_live && sb_i[src_a_i]) || (b_live && sb_i[src_b_i]);
  assign waw_hit = d_live && sb_i[dst_i];
  assign hit_o   = raw_hit || waw_hit;

  always_comb begin
    sb_o = sb_i;
    if (d_live) sb_o[dst_i] = 1'b1;
    if (stop_i) sb_o = '0;
  end
endmodule

// File: rtl/isg_first_pick.sv
module isg_first_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/isg_dep_checker.sv
module isg_dep_checker
  import isg_pkg::*;
#(
  parameter int NREG  = ISG_NREG_DEF,
  parameter int SLOTS = ISG_SLOTS_DEF,
  localparam int RW = $clog2(NREG),
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bndl_vld_i,
  input  logic [SLOTS-1:0][RW-1:0]  slot_src_a_i,
  input  logic [SLOTS-1:0]          slot_src_a_vld_i,
  input  logic [SLOTS-1:0][RW-1:0]  slot_src_b_i,
  input  logic [SLOTS-1:0]          slot_src_b_vld_i,
  input  logic [SLOTS-1:0][RW-1:0]  slot_dst_i,
  input  logic [SLOTS-1:0]          slot_dst_vld_i,
  input  logic [SLOTS-1:0]          slot_mem_i,
  input  logic [SLOTS-1:0]          slot_stop_i,
  output logic                      viol_o,
  output logic [SW-1:0]             viol_slot_o,
  output logic [SLOTS-1:0]          viol_map_o
);
  logic [NREG-1:0]            sb_q;
  logic [SLOTS:0][NREG-1:0]   sb_chain;
  logic [SLOTS-1:0]           slot_hit;
  logic                       hit_any;
  logic [SW-1:0]              hit_idx;
  logic [SLOTS-1:0]           below_mask;

  assign sb_chain[0] = sb_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    isg_slot_stage #(.NREG(NREG)) u_stage (
      .sb_i        (sb_chain[g]),
      .src_a_i     (slot_src_a_i[g]),
      .src_a_vld_i (slot_src_a_vld_i[g]),
      .src_b_i     (slot_src_b_i[g]),
      .src_b_vld_i (slot_src_b_vld_i[g]),
      .dst_i       (slot_dst_i[g]),
      .dst_vld_i   (slot_dst_vld_i[g]),
      .stop_i      (slot_stop_i[g]),
      .hit_o       (slot_hit[g]),
      .sb_o        (sb_chain[g+1])
    );

    // R6
    mem_alone_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bndl_vld_i && slot_mem_i[g] && !slot_src_a_vld_i[g] && !slot_src_b_vld_i[g]
        && !slot_dst_vld_i[g] |=> !viol_map_o[g]);
  end

  isg_first_pick #(.N(SLOTS), .IW(SW)) u_pick (
    .req_i (slot_hit),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_q        <= '0;
      viol_o      <= 1'b0;
      viol_slot_o <= '0;
      viol_map_o  <= '0;
    end else if (bndl_vld_i) begin
      sb_q        <= sb_chain[SLOTS];
      viol_o      <= hit_any;
      viol_slot_o <= hit_idx;
      viol_map_o  <= slot_hit;
    end else begin
      viol_o      <= 1'b0;
      viol_slot_o <= '0;
      viol_map_o  <= '0;
    end
  end

  assign below_mask = SLOTS'((1 << viol_slot_o) - 1);

  // R7
  quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bndl_vld_i |=> !viol_o && (viol_map_o == '0));

  // R7
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> viol_map_o[viol_slot_o] && ((viol_map_o & below_mask) == '0));

  // R7
  pulse_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|viol_map_o) |-> viol_o);

  // R5
  zero_never_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_q[0]);

  // R3
  stop_tail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bndl_vld_i && slot_stop_i[SLOTS-1] |=> sb_q == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bndl_vld_i |=> $stable(sb_q));

  // R8
  record_despite_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bndl_vld_i && slot_dst_vld_i[0] && (slot_dst_i[0] != '0) && !(|slot_stop_i)
      |=> sb_q[$past(slot_dst_i[0])]);
endmodule

// File: tb/test_isg_dep_checker.sv
module test_isg_dep_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bndl_vld_i = 1'b0;
  logic [2:0][6:0] sa, sb, sd;
  logic [2:0] sav, sbv, sdv, mem, stp;
  logic viol_o;
  logic [1:0] viol_slot_o;
  logic [2:0] viol_map_o;

  int tot = 0;
  int bad = 0;
  bit model_sb [128];
  logic [2:0] exp_map;

  always #5 clk = ~clk;

  isg_dep_checker i_isg_dep_checker (
    .clk(clk), .rst_n(rst_n), .bndl_vld_i(bndl_vld_i),
    .slot_src_a_i(sa), .slot_src_a_vld_i(sav),
    .slot_src_b_i(sb), .slot_src_b_vld_i(sbv),
    .slot_dst_i(sd), .slot_dst_vld_i(sdv),
    .slot_mem_i(mem), .slot_stop_i(stp),
    .viol_o(viol_o), .viol_slot_o(viol_slot_o), .viol_map_o(viol_map_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit touched(input bit used, input logic [6:0] r);
    return used && (r != 7'd0) && model_sb[r];
  endfunction

  // model: walk slots in order, conflicts against what this group has written
  function automatic logic [2:0] predict();
    logic [2:0] m = '0;
    for (int k = 0; k < 3; k++) begin
      if (touched(sav[k], sa[k]) || touched(sbv[k], sb[k]) || touched(sdv[k], sd[k]))
        m[k] = 1'b1;
      if (sdv[k] && sd[k] != 7'd0) model_sb[sd[k]] = 1'b1;
      if (stp[k]) foreach (model_sb[j]) model_sb[j] = 1'b0;
    end
    return m;
  endfunction

  function automatic int lowest(input logic [2:0] m);
    if (m[0]) return 0;
    if (m[1]) return 1;
    if (m[2]) return 2;
    return 0;
  endfunction

  task automatic clr();
    sa = '0; sb = '0; sd = '0;
    sav = '0; sbv = '0; sdv = '0; mem = '0; stp = '0;
  endtask

  task automatic push(input string tag);
    exp_map = predict();
    bndl_vld_i = 1'b1;
    @(posedge clk);
    #2;
    chk(viol_map_o == exp_map, {tag, " R7 map"}, viol_map_o, exp_map);
    chk(viol_o == (exp_map != 0), {tag, " R7 pulse"}, viol_o, exp_map != 0);
    chk(viol_slot_o == lowest(exp_map), {tag, " R7 slot"}, viol_slot_o, lowest(exp_map));
    clr();
  endtask

  task automatic idle(input string tag);
    bndl_vld_i = 1'b0;
    @(posedge clk);
    #2;
    chk(!viol_o && viol_map_o == 0 && viol_slot_o == 0, {tag, " R7 idle quiet"},
        {viol_o, viol_map_o}, 0);
  endtask

  initial begin
    #2_000_000;
    tot++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", tot, 0);
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    repeat (3) @(posedge clk);
    #2;
    chk(!viol_o && viol_map_o == 0, "R10 reset outputs", {viol_o, viol_map_o}, 0);
    rst_n = 1'b1;

    // R10: empty scoreboard after reset, reads see nothing
    sav = 3'b111; sa[0] = 7'd5; sa[1] = 7'd9; sa[2] = 7'd33;
    push("R10 empty");
    stp[2] = 1'b1; push("R3 flush");

    // R1 in-bundle RAW: slot0 writes r5, slot1 reads r5
    sdv[0] = 1; sd[0] = 7'd5; sav[1] = 1; sa[1] = 7'd5; stp[2] = 1;
    push("R1 raw in bundle");
    chk(exp_map == 3'b010, "R1 expect slot1", exp_map, 3'b010);

    // R4 / R2: WAW across bundles with no stop
    sdv[2] = 1; sd[2] = 7'd40; push("R4 first");
    sdv[1] = 1; sd[1] = 7'd40; stp[2] = 1; push("R2 waw across");
    chk(exp_map == 3'b010, "R2 expect slot1", exp_map, 3'b010);

    // R3 mid-bundle stop: slot0 writes r6 and stops, slot1 reads r6
    sdv[0] = 1; sd[0] = 7'd6; stp[0] = 1; sbv[1] = 1; sb[1] = 7'd6;
    sdv[2] = 1; sd[2] = 7'd6; push("R3 mid stop");
    chk(exp_map == 3'b000, "R3 expect none", exp_map, 0);
    stp[0] = 1; push("R3 flush2");

    // R5 register 0
    sdv = 3'b111; sav = 3'b111; push("R5 zero regs");
    chk(exp_map == 3'b000, "R5 expect none", exp_map, 0);

    // R6 WAR and double reads with memory flags set
    mem = 3'b111; sav[0] = 1; sa[0] = 7'd9; sav[1] = 1; sa[1] = 7'd9;
    sdv[2] = 1; sd[2] = 7'd9; stp[2] = 1; push("R6 war mem");
    chk(exp_map == 3'b000, "R6 expect none", exp_map, 0);

    // R8 flagged slot still records; R9 idle keeps it; R7 first of two
    sdv[0] = 1; sd[0] = 7'd4; sdv[1] = 1; sd[1] = 7'd4; sdv[2] = 1; sd[2] = 7'd4;
    push("R8 waw chain");
    chk(exp_map == 3'b110, "R7 two offenders", exp_map, 3'b110);
    idle("R9 gap1"); idle("R9 gap2");
    sav[0] = 1; sa[0] = 7'd4; stp[2] = 1; push("R9 held");
    chk(exp_map == 3'b001, "R9 expect slot0", exp_map, 3'b001);

    // random stream, small register pool for frequent hazards
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 3; k++) begin
        sa[k] = 7'($urandom % 8); sb[k] = 7'($urandom % 8);
        sd[k] = ($urandom % 10 == 0) ? 7'($urandom) : 7'($urandom % 8);
        sav[k] = $urandom % 2; sbv[k] = $urandom % 3 == 0; sdv[k] = $urandom % 2;
        mem[k] = $urandom % 2; stp[k] = $urandom % 5 == 0;
      end
      if ($urandom % 8 == 0) idle("R9 rand idle");
      push("rand R1 R2 R3");
    end

    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule